// File: doc/BRIEF.md
# Zero-Turnaround Pipelined SRAM Core

This block is a synchronous single-port memory whose reads and writes share one fixed pipeline. A command, made up of the address, direction and byte-lane enables, is captured on a rising edge. Its data beat happens two active edges later. Read data is driven onto the bus after that edge. Write data is taken from the bus at that edge. Because both directions have the same latency, a read can follow a write, or a write can follow a read, on the very next cycle with no idle cycle between them.

A clock enable freezes the whole pipeline. A cycle in which clock enable is inactive does not count toward the two-edge latency. Three chip selects gate the start of new operations, and operations already in flight still complete.

A load/advance strobe either loads a new address or continues a four-beat burst from the last one. A parameter picks the burst order: sequential or XOR. An asynchronous output enable can silence the bus at any moment. The bidirectional bus is modelled as separate input data, output data and a drive-enable.

Top module: `zt_sram_core`

## Requirements
- R1: A read command captured at an active edge places the addressed word on `dq_out` with `dq_oe` high right after the second active edge that follows. Both hold until the next active edge.
- R2: A write command captured at an active edge stores `dq_in` as sampled at the second active edge that follows.
- R3: A new operation is started only at an active edge with `adv_ld` low, `cs0_n` low, `cs1` high and `cs2_n` low. If any one select is off, the cycle starts nothing, and a write issued in such a cycle changes no word.
- R4: Deselecting does not cancel operations already captured; they still finish. The bus drive ends two active edges after a deselected cycle.
- R5: `dq_oe` is low after the data edge of a write, that is, two active edges after the write command. A read and a write may be issued on consecutive cycles in either order.
- R6: `oe_n` high forces `dq_oe` low at once, without waiting for a clock. It leaves the pipeline untouched, so the read data reappears when `oe_n` returns low.
- R7: The word is split into 9-bit lanes, with lane i occupying bits [9i+8:9i]. On a write, only the lanes whose `lane_we` bit was 1 at the command edge are updated.
- R8: While `cen_n` is high, no input is sampled and `dq_out`, `dq_oe` and all pipeline stages hold their values. Stalled cycles do not count toward the latency.
- R9: A read returns the latest data written to its address, including data from a write issued on the cycle just before the read.
- R10: `adv_ld` high after a started operation starts another beat of the same direction. The chip selects and `wr_sel` are ignored, and `lane_we` is sampled anew. The address bits above bit 1 stay at the loaded value. The low two bits become (start + n) mod 4 when BURST_XOR=0, or start XOR n when BURST_XOR=1, for beat n.
- R11: `adv_ld` high when the previous active cycle started nothing starts nothing.
- R12: During and right after reset, no operation is in flight and `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cen_n | input | 1 | Clock enable, low active; high freezes everything |
| cs0_n | input | 1 | Chip select, low active |
| cs1 | input | 1 | Chip select, high active |
| cs2_n | input | 1 | Chip select, low active |
| adv_ld | input | 1 | Low loads a new address, high advances the burst |
| wr_sel | input | 1 | 1 = write, 0 = read |
| lane_we | input | DATA_W/9 | Per-lane write enables, high active |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Asynchronous output enable, low active |
| dq_in | input | DATA_W | Bus data into the memory |
| dq_out | output | DATA_W | Registered read data |
| dq_oe | output | 1 | Bus drive enable |

## Verification
A wrong stage register shows up as a read word, or a drive window, that is displaced by one edge. Such an error is visible on `dq_oe` exactly two active edges after the command that was disturbed. A corrupted lane mask or burst counter stays hidden until the affected address is read back, which the bench does three edges later. A clock-enable leak shows up immediately as `dq_out` or `dq_oe` moving during a stalled cycle. The asynchronous output-enable path shows up within the same clock phase.

// File: rtl/zt_pkg.sv
package zt_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // low two address bits for beat number `beat` of a burst that began at `start`
  function automatic logic [1:0] burst_ofs(input logic [1:0] start,
                                           input logic [1:0] beat,
                                           input logic       xor_mode);
    return xor_mode ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/zt_cmd_capture.sv
module zt_cmd_capture
  import zt_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int LANES     = 4,
  parameter bit BURST_XOR = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cen_n,
  input  logic              cs0_n,
  input  logic              cs1,
  input  logic              cs2_n,
  input  logic              adv_ld,
  input  logic              wr_sel,
  input  logic [LANES-1:0]  lane_we,
  input  logic [ADDR_W-1:0] addr,
  output op_e               op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LANES-1:0]  be_q
);

  logic              all_sel;
  logic [1:0]        beat_q;
  logic [1:0]        beat_nx;
  logic [ADDR_W-1:0] base_q;

  assign all_sel = !cs0_n && cs1 && !cs2_n;
  assign beat_nx = beat_q + 2'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_IDLE;
      addr_q <= '0;
      be_q   <= '0;
      base_q <= '0;
      beat_q <= '0;
    end else if (!cen_n) begin
      be_q <= lane_we;
      if (!adv_ld) begin
        base_q <= addr;
        addr_q <= addr;
        beat_q <= '0;
        if (all_sel) op_q <= wr_sel ? OP_WRITE : OP_READ;
        else         op_q <= OP_IDLE;
      end else if (op_q != OP_IDLE) begin
        beat_q <= beat_nx;
        addr_q <= {base_q[ADDR_W-1:2], burst_ofs(base_q[1:0], beat_nx, BURST_XOR)};
      end
    end
  end

  // R3: a load with all selects on always starts an operation
  a_r3_load_starts : assert property (@(posedge clk) disable iff (rst)
    (!cen_n && !adv_ld && !cs0_n && cs1 && !cs2_n) |=> (op_q != OP_IDLE));

  // R3: a load with any select off starts nothing
  a_r3_deselect_idle : assert property (@(posedge clk) disable iff (rst)
    (!cen_n && !adv_ld && (cs0_n || !cs1 || cs2_n)) |=> (op_q == OP_IDLE));

  // R10: a continuing beat keeps the direction of the burst
  a_r10_burst_dir : assert property (@(posedge clk) disable iff (rst)
    (!cen_n && adv_ld && op_q != OP_IDLE) |=> (op_q == $past(op_q)));

  // R11: advancing from an idle cycle stays idle
  a_r11_no_chain : assert property (@(posedge clk) disable iff (rst)
    (!cen_n && adv_ld && op_q == OP_IDLE) |=> (op_q == OP_IDLE));

endmodule

// File: rtl/zt_lane_ram.sv
module zt_lane_ram #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wd,
  output logic [LANE_W-1:0] rd
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  // single-port array with registered read, clock-enabled as a whole
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wd;
      if (re) rd <= mem[addr];
    end
  end

  // R9: the stage never reads and writes the array in the same cycle
  a_r9_single_access : assert property (@(posedge clk)
    en |-> !(we && re));

endmodule

// File: rtl/zt_sram_core.sv
module zt_sram_core
  import zt_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 36,
  parameter int LANE_W    = 9,
  parameter bit BURST_XOR = 1'b0,
  localparam int LANES    = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cen_n,
  input  logic              cs0_n,
  input  logic              cs1,
  input  logic              cs2_n,
  input  logic              adv_ld,
  input  logic              wr_sel,
  input  logic [LANES-1:0]  lane_we,
  input  logic [ADDR_W-1:0] addr,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  op_e               op1;
  logic [ADDR_W-1:0] addr1;
  logic [LANES-1:0]  be1;

  op_e               op2;
  logic [ADDR_W-1:0] addr2;
  logic [LANES-1:0]  be2;
  logic              drive_q;

  zt_cmd_capture #(
    .ADDR_W   (ADDR_W),
    .LANES    (LANES),
    .BURST_XOR(BURST_XOR)
  ) u_capture (
    .clk    (clk),
    .rst    (rst),
    .cen_n  (cen_n),
    .cs0_n  (cs0_n),
    .cs1    (cs1),
    .cs2_n  (cs2_n),
    .adv_ld (adv_ld),
    .wr_sel (wr_sel),
    .lane_we(lane_we),
    .addr   (addr),
    .op_q   (op1),
    .addr_q (addr1),
    .be_q   (be1)
  );

  // second stage: the command whose data beat happens at the next active edge
  always_ff @(posedge clk) begin
    if (rst) begin
      op2     <= OP_IDLE;
      addr2   <= '0;
      be2     <= '0;
      drive_q <= 1'b0;
    end else if (!cen_n) begin
      op2     <= op1;
      addr2   <= addr1;
      be2     <= be1;
      drive_q <= (op2 == OP_READ);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    zt_lane_ram #(
      .ADDR_W(ADDR_W),
      .LANE_W(LANE_W)
    ) u_ram (
      .clk (clk),
      .en  (!cen_n),
      .we  ((op2 == OP_WRITE) && be2[g]),
      .re  (op2 == OP_READ),
      .addr(addr2),
      .wd  (dq_in[g*LANE_W +: LANE_W]),
      .rd  (dq_out[g*LANE_W +: LANE_W])
    );
  end

  assign dq_oe = drive_q && !oe_n;

  // R12: reset empties the pipeline and releases the bus
  a_r12_reset_clear : assert property (@(posedge clk)
    rst |=> (op2 == OP_IDLE && !drive_q));

  // R8: a stalled cycle changes neither stage two nor the drive flag
  a_r8_freeze : assert property (@(posedge clk) disable iff (rst)
    cen_n |=> ($stable(op2) && $stable(drive_q)));

  // R8: an active edge moves stage one into stage two
  a_r8_advance : assert property (@(posedge clk) disable iff (rst)
    !cen_n |=> (op2 == $past(op1)));

  // R1: a read data beat turns the drive on
  a_r1_read_drives : assert property (@(posedge clk) disable iff (rst)
    (!cen_n && op2 == OP_READ) |=> drive_q);

  // R5: a write data beat leaves the bus undriven
  a_r5_write_release : assert property (@(posedge clk) disable iff (rst)
    (!cen_n && op2 == OP_WRITE) |=> !dq_oe);

endmodule

// File: tb/zt_sram_core_tb.sv
`timescale 1ns/1ps
module zt_sram_core_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cen_n = 1'b0;
  logic        cs0_n = 1'b1;
  logic        cs1 = 1'b0;
  logic        cs2_n = 1'b1;
  logic        adv_ld = 1'b0;
  logic        wr_sel = 1'b0;
  logic [3:0]  lane_we = 4'h0;
  logic [5:0]  addr = '0;
  logic        oe_n = 1'b0;
  logic [35:0] dq_in = '0;
  logic [35:0] q0, q1;
  logic        oe0, oe1;

  int total = 0;
  int bad = 0;
  bit done = 0;

  localparam logic [35:0] DA = 36'h1A2B3C4D5, DB = 36'h5C0FFEE01, DF = 36'hFFFFFFFFF;
  localparam logic [35:0] DG = 36'h123456789, J0 = 36'hDEADBEEF0;
  localparam logic [35:0] B0 = 36'h000000B00, B1 = 36'h0000B1000, B2 = 36'h00B200000, B3 = 36'hB30000000;

  always #4 clk = ~clk;

  zt_sram_core #(.ADDR_W(6), .DATA_W(36), .LANE_W(9), .BURST_XOR(1'b0)) u_dut (
    .clk(clk), .rst(rst), .cen_n(cen_n), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
    .adv_ld(adv_ld), .wr_sel(wr_sel), .lane_we(lane_we), .addr(addr), .oe_n(oe_n),
    .dq_in(dq_in), .dq_out(q0), .dq_oe(oe0));

  zt_sram_core #(.ADDR_W(6), .DATA_W(36), .LANE_W(9), .BURST_XOR(1'b1)) u_dut_x (
    .clk(clk), .rst(rst), .cen_n(cen_n), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
    .adv_ld(adv_ld), .wr_sel(wr_sel), .lane_we(lane_we), .addr(addr), .oe_n(oe_n),
    .dq_in(dq_in), .dq_out(q1), .dq_oe(oe1));

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle from a falling edge: sel 0 = all selected, 1/2/3 = one select off
  task automatic cyc(input logic c_n, input logic adv, input int sel, input logic w,
                     input int a, input logic [3:0] be, input logic [35:0] d);
    cen_n   = c_n;
    adv_ld  = adv;
    cs0_n   = (sel == 1);
    cs1     = (sel != 2);
    cs2_n   = (sel == 3);
    wr_sel  = w;
    addr    = a[5:0];
    lane_we = be;
    dq_in   = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic nop(input logic [35:0] d);
    cyc(1'b0, 1'b0, 2, 1'b0, 0, 4'h0, d);
  endtask

  task automatic rd_chk(input string tag, input int a, input logic [35:0] e0, input logic [35:0] e1);
    cyc(1'b0, 1'b0, 0, 1'b0, a, 4'h0, J0);
    nop(J0);
    nop(J0);
    chk({tag, " oe"}, {35'd0, oe0}, 36'd1);
    chk({tag, " data"}, q0, e0);
    chk({tag, " data xor"}, q1, e1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R12 oe in reset", {35'd0, oe0}, 36'd0);
    rst = 1'b0;
    nop(J0);
    nop(J0);
    chk("R12 oe after reset", {35'd0, oe0}, 36'd0);
  endtask

  task automatic t_write_read;
    cyc(1'b0, 1'b0, 0, 1'b1, 3, 4'hF, J0);
    nop(J0);
    nop(DA);
    rd_chk("R1 R2 read back", 3, DA, DA);
    nop(J0);
    chk("R4 drive ends after deselect", {35'd0, oe0}, 36'd0);
  endtask

  task automatic t_back_to_back;
    cyc(1'b0, 1'b0, 0, 1'b1, 10, 4'hF, J0);
    cyc(1'b0, 1'b0, 0, 1'b0, 10, 4'h0, J0);
    cyc(1'b0, 1'b0, 0, 1'b1, 11, 4'hF, DA);
    cyc(1'b0, 1'b0, 0, 1'b0, 11, 4'h0, J0);
    chk("R9 read after write oe", {35'd0, oe0}, 36'd1);
    chk("R9 read after write data", q0, DA);
    nop(DB);
    chk("R5 write beat releases bus", {35'd0, oe0}, 36'd0);
    nop(J0);
    chk("R5 read right after write oe", {35'd0, oe0}, 36'd1);
    chk("R5 read right after write data", q0, DB);
    nop(J0);
    chk("R4 idle after read", {35'd0, oe0}, 36'd0);
  endtask

  task automatic t_lanes;
    cyc(1'b0, 1'b0, 0, 1'b1, 20, 4'hF, J0);
    cyc(1'b0, 1'b0, 0, 1'b1, 20, 4'b0101, J0);
    nop(DF);
    nop(DG);
    rd_chk("R7 masked lanes", 20, {9'h1FF, DG[26:18], 9'h1FF, DG[8:0]},
           {9'h1FF, DG[26:18], 9'h1FF, DG[8:0]});
  endtask

  task automatic t_stall;
    cyc(1'b0, 1'b0, 0, 1'b0, 10, 4'h0, J0);
    nop(J0);
    cyc(1'b1, 1'b0, 0, 1'b1, 11, 4'hF, J0);
    chk("R8 stall no early drive", {35'd0, oe0}, 36'd0);
    cyc(1'b1, 1'b0, 0, 1'b1, 11, 4'hF, J0);
    chk("R8 stall still silent", {35'd0, oe0}, 36'd0);
    nop(J0);
    chk("R8 latency after stall oe", {35'd0, oe0}, 36'd1);
    chk("R8 latency after stall data", q0, DA);
    cyc(1'b1, 1'b0, 0, 1'b0, 0, 4'h0, J0);
    chk("R8 frozen oe", {35'd0, oe0}, 36'd1);
    chk("R8 frozen data", q0, DA);
    nop(J0);
    chk("R8 release", {35'd0, oe0}, 36'd0);
    rd_chk("R8 stalled write ignored", 11, DB, DB);
  endtask

  task automatic t_oe;
    cyc(1'b0, 1'b0, 0, 1'b0, 11, 4'h0, J0);
    nop(J0);
    nop(J0);
    oe_n = 1'b1;
    #1;
    chk("R6 async off", {35'd0, oe0}, 36'd0);
    oe_n = 1'b0;
    #1;
    chk("R6 back on", {35'd0, oe0}, 36'd1);
    chk("R6 data kept", q0, DB);
  endtask

  task automatic t_deselect;
    cyc(1'b0, 1'b0, 0, 1'b0, 10, 4'h0, J0);
    cyc(1'b0, 1'b0, 1, 1'b0, 0, 4'h0, J0);
    nop(J0);
    chk("R4 in-flight read completes", q0, DA);
    chk("R4 in-flight oe", {35'd0, oe0}, 36'd1);
    nop(J0);
    chk("R4 drive ends", {35'd0, oe0}, 36'd0);
    cyc(1'b0, 1'b0, 3, 1'b1, 10, 4'hF, J0);
    cyc(1'b0, 1'b0, 2, 1'b0, 10, 4'h0, J0);
    nop(J0);
    chk("R3 partial select no write beat drive", {35'd0, oe0}, 36'd0);
    nop(J0);
    chk("R3 partial select read not driven", {35'd0, oe0}, 36'd0);
    rd_chk("R3 deselected write ignored", 10, DA, DA);
  endtask

  task automatic t_no_chain;
    nop(J0);
    cyc(1'b0, 1'b1, 0, 1'b0, 10, 4'h0, J0);
    nop(J0);
    chk("R11 no start", {35'd0, oe0}, 36'd0);
    nop(J0);
    chk("R11 no data beat", {35'd0, oe0}, 36'd0);
  endtask

  task automatic t_burst;
    cyc(1'b0, 1'b0, 0, 1'b1, 33, 4'hF, J0);
    cyc(1'b0, 1'b1, 2, 1'b0, 0, 4'hF, J0);
    cyc(1'b0, 1'b1, 2, 1'b0, 0, 4'hF, B0);
    cyc(1'b0, 1'b1, 2, 1'b0, 0, 4'hF, B1);
    nop(B2);
    nop(B3);
    nop(J0);
    rd_chk("R10 burst word 32", 32, B3, B1);
    rd_chk("R10 burst word 33", 33, B0, B0);
    rd_chk("R10 burst word 34", 34, B1, B3);
    rd_chk("R10 burst word 35", 35, B2, B2);
    cyc(1'b0, 1'b0, 0, 1'b0, 35, 4'h0, J0);
    cyc(1'b0, 1'b1, 2, 1'b0, 0, 4'h0, J0);
    cyc(1'b0, 1'b1, 2, 1'b1, 0, 4'hF, J0);
    chk("R10 read beat0", q0, B2);
    chk("R10 read beat0 xor", q1, B2);
    nop(J0);
    chk("R10 read beat1", q0, B3);
    chk("R10 read beat1 xor", q1, B3);
    chk("R10 read beat1 oe", {35'd0, oe0}, 36'd1);
    nop(J0);
    chk("R10 read beat2", q0, B0);
    chk("R10 read beat2 xor", q1, B0);
    chk("R10 read beat2 oe", {35'd0, oe1}, 36'd1);
    nop(J0);
    chk("R10 burst ends", {35'd0, oe0}, 36'd0);
  endtask

  initial begin
    t_reset();
    t_write_read();
    t_back_to_back();
    t_lanes();
    t_stall();
    t_oe();
    t_deselect();
    t_no_chain();
    t_burst();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule